// File: doc/BRIEF.md
# Dynamic Bus Width Cycle Splitter

This block sits between a core and an external memory or I/O bus. The core hands it one word-aligned 32-bit read or write at a time, with a byte-enable mask. The block runs the transfer on the external bus and answers with a single response. It takes the same view of every target, because the target's data width is not known ahead of time. The responding device reports its width in the same clock in which it signals ready, through a narrow-width flag. When a 16-bit target answers a transfer that touches both halves of the word, the controller runs a follow-up bus cycle for the upper half on its own. Write bytes are steered onto the low lanes and the read halves are joined back together. The core cannot tell the two cases apart.

Each bus cycle can have any number of wait states: it ends at the first rising clock edge at which ready is high. The narrow-width flag matters only at that edge. Byte enables that fall entirely in one half never cause a second cycle. For a transfer that uses only the upper half, the upper write bytes are also copied onto the low lanes. A read of the upper half from a narrow device is taken from the low lanes.

Top module: `bsz_split_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, `bus_cyc` is 0 and `rsp_valid` is 0.
- R2: When ready is sampled high with the narrow flag low, the transfer ends after that single cycle. The first cycle's `bus_addr` is the word address with bits 1:0 at zero, and `bus_be` equals the request's enables. `rsp_rdata` is the bus word with every byte whose enable bit is 0 forced to zero.
- R3: While ready is low, `bus_cyc`, `bus_addr`, `bus_be`, `bus_we` and `bus_wdata` hold their values. The narrow flag has no effect in any clock in which ready is low.
- R4: If ready is sampled high with the narrow flag high, and the enables include at least one byte of 1:0 and at least one byte of 3:2, a second bus cycle follows at once. In that cycle `bus_addr` is the first address plus 2 and `bus_be` is {request be[3:2], 2'b00}. Write bytes 3:2 are driven on lanes 15:0 as well as on 31:16.
- R5: For such a split read, bytes 1:0 of the response come from lanes 15:0 of the first cycle and bytes 3:2 from lanes 15:0 of the second cycle. Disabled bytes read as zero. Exactly one `rsp_valid` is given, after the second cycle.
- R6: If the enables select bytes from only one half, or no byte at all, one bus cycle ends the transfer whatever the narrow flag is.
- R7: When be[1:0] is 0, `bus_wdata[15:0]` carries the same value as `bus_wdata[31:16]`. If such a read ends with the narrow flag high, bus lanes 15:0 are returned in response bytes 3:2 and bytes 1:0 read as zero.
- R8: `req_ready` is 1 only while no transfer is in progress. `rsp_valid` is a one-clock pulse in the clock after the final ready edge, and the block is ready again in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a transfer |
| req_ready | output | 1 | Controller is idle and accepts the transfer |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W-2 | Word address of the transfer |
| req_be | input | 4 | Byte enables, bit i selects byte i |
| req_wdata | input | 32 | Write data, byte i on bits 8i+7:8i |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Assembled read data (zero for writes) |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_we | output | 1 | Direction of the current bus cycle |
| bus_addr | output | ADDR_W | Byte address of the current bus cycle |
| bus_be | output | 4 | Byte enables of the current bus cycle |
| bus_wdata | output | 32 | Write lanes of the current bus cycle |
| bus_rdata | input | 32 | Read lanes from the device |
| bus_rdy | input | 1 | Device ends the current cycle |
| bus_bs16 | input | 1 | Device is 16 bits wide, sampled with ready |

## Verification
All sixteen byte-enable masks are written and then read back, once against a 32-bit device region and once against a 16-bit one. Wait-state counts vary from zero to two. The wide runs confirm that one cycle is used and that disabled bytes are masked. In the narrow runs, masks touching both halves must produce exactly two cycles with the shifted address and upper-only enables. Low-only, high-only and empty masks must stay at one cycle, and high-only masks are the case that exposes the steering of lanes 15:0. The narrow flag is driven with the wrong value during every wait state, so sampling it early shows up as a wrong cycle count. The upper lanes of the 16-bit device carry junk, so a merge that takes the wrong lanes shows up in the read data.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CYC1 = 2'd1,
        ST_CYC2 = 2'd2,
        ST_DONE = 2'd3
    } bsz_state_e;
endpackage

// File: rtl/bsz_lane_steer.sv
// Chooses byte enables and write lanes for the first or follow-up cycle.
module bsz_lane_steer #(
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8
) (
    input  logic              second,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [BE_W-1:0]   bus_be,
    output logic [DATA_W-1:0] bus_wdata
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int HALF_BE = BE_W / 2;

    logic              hi_only;
    logic [HALF_W-1:0] upper;

    always_comb begin
        upper   = wdata[DATA_W-1:HALF_W];
        hi_only = (be[HALF_BE-1:0] == '0);
        if (second) begin
            bus_be    = {be[BE_W-1:HALF_BE], {HALF_BE{1'b0}}};
            bus_wdata = {upper, upper};
        end else begin
            bus_be    = be;
            bus_wdata = hi_only ? {upper, upper} : wdata;
        end
    end
endmodule

// File: rtl/bsz_read_merge.sv
// Builds the response word from the current cycle's lanes and the held low half.
module bsz_read_merge #(
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              second,
    input  logic              bs16,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [HALF_W-1:0] held_lo,
    output logic [DATA_W-1:0] merged,
    output logic              need_second
);
    localparam int HALF_BE = BE_W / 2;

    logic              lo_used;
    logic              hi_used;
    logic [HALF_W-1:0] lanes_lo;
    logic [DATA_W-1:0] raw;

    always_comb begin
        lo_used     = |be[HALF_BE-1:0];
        hi_used     = |be[BE_W-1:HALF_BE];
        lanes_lo    = bus_rdata[HALF_W-1:0];
        need_second = !second && bs16 && lo_used && hi_used;
        if (second) begin
            raw = {lanes_lo, held_lo};
        end else if (!bs16) begin
            raw = bus_rdata;
        end else if (!lo_used) begin
            raw = {lanes_lo, {HALF_W{1'b0}}};
        end else begin
            raw = {{HALF_W{1'b0}}, lanes_lo};
        end
    end

    for (genvar gi = 0; gi < BE_W; gi++) begin : g_mask
        assign merged[8*gi +: 8] = raw[8*gi +: 8] & {8{be[gi]}};
    end
endmodule

// File: rtl/bsz_split_ctrl.sv
module bsz_split_ctrl
    import bsz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8,
    localparam int WORD_LSB = $clog2(BE_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_we,
    input  logic [ADDR_W-1:WORD_LSB]   req_addr,
    input  logic [BE_W-1:0]            req_be,
    input  logic [DATA_W-1:0]          req_wdata,
    output logic                       rsp_valid,
    output logic [DATA_W-1:0]          rsp_rdata,
    output logic                       bus_cyc,
    output logic                       bus_we,
    output logic [ADDR_W-1:0]          bus_addr,
    output logic [BE_W-1:0]            bus_be,
    output logic [DATA_W-1:0]          bus_wdata,
    input  logic [DATA_W-1:0]          bus_rdata,
    input  logic                       bus_rdy,
    input  logic                       bus_bs16
);
    localparam int HALF_W     = DATA_W / 2;
    localparam int HALF_BYTES = BE_W / 2;

    typedef struct packed {
        bsz_state_e          st;
        logic                we;
        logic [ADDR_W-1:0]   addr;
        logic [BE_W-1:0]     be;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              in_second;
    logic [DATA_W-1:0] merged;
    logic              need_second;

    assign in_second = (ctl_q.st == ST_CYC2);

    bsz_lane_steer #(.DATA_W(DATA_W)) steer_i (
        .second    (in_second),
        .be        (ctl_q.be),
        .wdata     (ctl_q.wdata),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata)
    );

    bsz_read_merge #(.DATA_W(DATA_W)) merge_i (
        .second      (in_second),
        .bs16        (bus_bs16),
        .be          (ctl_q.be),
        .bus_rdata   (bus_rdata),
        .held_lo     (ctl_q.rdata[HALF_W-1:0]),
        .merged      (merged),
        .need_second (need_second)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_CYC1;
                    ctl_d.we    = req_we;
                    ctl_d.addr  = {req_addr, {WORD_LSB{1'b0}}};
                    ctl_d.be    = req_be;
                    ctl_d.wdata = req_wdata;
                    ctl_d.rdata = '0;
                end
            end
            ST_CYC1: begin
                if (bus_rdy) begin
                    ctl_d.rdata = ctl_q.we ? '0 : merged;
                    ctl_d.st    = need_second ? ST_CYC2 : ST_DONE;
                end
            end
            ST_CYC2: begin
                if (bus_rdy) begin
                    ctl_d.rdata = ctl_q.we ? '0 : merged;
                    ctl_d.st    = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign bus_cyc   = (ctl_q.st == ST_CYC1) || in_second;
    assign bus_we    = ctl_q.we && bus_cyc;
    assign bus_addr  = ctl_q.addr + (in_second ? ADDR_W'(HALF_BYTES) : '0);
    assign rsp_valid = (ctl_q.st == ST_DONE);
    assign rsp_rdata = ctl_q.rdata;
endmodule

// File: rtl/bsz_split_ctrl_chk.sv
module bsz_split_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BE_W = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              bus_cyc,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rdy,
    input logic              bus_bs16
);
    localparam int HALF_W  = DATA_W / 2;
    localparam int HALF_BE = BE_W / 2;

    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_rdy) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_be)
                                   && $stable(bus_we) && $stable(bus_wdata))); // R3

    AST_SPLIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_rdy && bus_bs16 && (|bus_be[HALF_BE-1:0]) && (|bus_be[BE_W-1:HALF_BE]))
        |=> (bus_cyc && (bus_addr == $past(bus_addr) + ADDR_W'(HALF_BE))
             && (bus_be[HALF_BE-1:0] == '0))); // R4

    AST_WIDE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_rdy && !bus_bs16) |=> (rsp_valid && !bus_cyc)); // R2

    AST_HALF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_rdy && ((bus_be[HALF_BE-1:0] == '0) || (bus_be[BE_W-1:HALF_BE] == '0)))
        |=> rsp_valid); // R6

    AST_HIGH_LANES_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && (bus_be[HALF_BE-1:0] == '0))
        |-> (bus_wdata[HALF_W-1:0] == bus_wdata[DATA_W-1:HALF_W])); // R7

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready)); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc || rsp_valid) |-> !req_ready); // R8
endmodule

bind bsz_split_ctrl bsz_split_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .bus_cyc   (bus_cyc),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdy   (bus_rdy),
    .bus_bs16  (bus_bs16)
);

// File: tb/bsz_split_ctrl_tb_top.sv
`timescale 1ns/1ps
module bsz_split_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [29:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        bus_cyc;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_rdy = 1'b0;
    logic        bus_bs16 = 1'b0;

    always #5 clk = ~clk;

    bsz_split_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy), .bus_bs16(bus_bs16)
    );

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] dev_mem [32];
    logic [31:0] shadow  [32];

    int          cur_waits = 0;
    int          n_cyc = 0;
    bit          hold_err = 1'b0;
    logic [31:0] sec_addr = '0;
    logic [3:0]  sec_be = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] be_mask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    // Device model: addresses with bit 6 set are a 16-bit device.
    initial begin : responder
        int          wcnt;
        bit          have_ref;
        logic [31:0] ref_addr, ref_wd;
        logic [3:0]  ref_be;
        logic [4:0]  idx;
        int          half;
        logic [1:0]  hbe;
        wcnt = 0; have_ref = 0; ref_addr = '0; ref_wd = '0; ref_be = '0;
        forever begin
            @(negedge clk);
            if (!rst_n || !bus_cyc) begin
                bus_rdy = 1'b0; bus_bs16 = 1'b1; wcnt = 0; have_ref = 0;
            end else begin
                if (!have_ref) begin
                    ref_addr = bus_addr; ref_be = bus_be; ref_wd = bus_wdata; have_ref = 1;
                end else if (bus_addr != ref_addr || bus_be != ref_be || bus_wdata != ref_wd) begin
                    hold_err = 1'b1;
                end
                if (wcnt >= cur_waits) begin
                    bus_rdy = 1'b1;
                    n_cyc++;
                    if (n_cyc == 2) begin sec_addr = bus_addr; sec_be = bus_be; end
                    idx = {bus_addr[6], bus_addr[5:2]};
                    if (bus_addr[6]) begin
                        bus_bs16 = 1'b1;
                        half = (bus_addr[1] || bus_be[1:0] == 2'b00) ? 1 : 0;
                        hbe  = half ? bus_be[3:2] : bus_be[1:0];
                        if (bus_we)
                            for (int b = 0; b < 2; b++)
                                if (hbe[b]) dev_mem[idx][16*half + 8*b +: 8] = bus_wdata[8*b +: 8];
                        bus_rdata = {16'hDEAD, half ? dev_mem[idx][31:16] : dev_mem[idx][15:0]};
                    end else begin
                        bus_bs16 = 1'b0;
                        if (bus_we)
                            for (int b = 0; b < 4; b++)
                                if (bus_be[b]) dev_mem[idx][8*b +: 8] = bus_wdata[8*b +: 8];
                        bus_rdata = dev_mem[idx];
                    end
                    wcnt = 0; have_ref = 0;
                end else begin
                    bus_rdy   = 1'b0;
                    bus_bs16  = !bus_addr[6];   // wrong value on purpose while waiting
                    bus_rdata = 32'hBAD0BAD0;
                    wcnt++;
                end
            end
        end
    end

    task automatic do_op(input bit we, input logic [31:0] a, input logic [3:0] be,
                         input logic [31:0] wd, input int w,
                         output logic [31:0] rd, output int cyc, output bit to, output bit post_ok);
        cur_waits = w; n_cyc = 0; hold_err = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a[31:2]; req_be = be; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        to = 1'b1;
        for (int k = 0; k < 60; k++) begin
            if (rsp_valid) begin to = 1'b0; break; end
            @(negedge clk);
        end
        rd  = rsp_rdata;
        cyc = n_cyc;
        @(negedge clk);
        post_ok = !rsp_valid && req_ready;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fails++;
        n_checks++;
        $display("FAIL R8 watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] rd, a, wd, exp;
        int          cyc, exp_c;
        bit          to, post_ok, split, hi_only;
        string       rtag;
        for (int i = 0; i < 32; i++) begin
            dev_mem[i] = 32'hC0DE0000 + i * 32'h00010203;
            shadow[i]  = dev_mem[i];
        end
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && bus_cyc == 1'b0 && rsp_valid == 1'b0, "R1 reset",
            {29'd0, req_ready, bus_cyc, rsp_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && bus_cyc == 1'b0 && rsp_valid == 1'b0, "R1 after reset",
            {29'd0, req_ready, bus_cyc, rsp_valid}, 32'h4);

        for (int nar = 0; nar < 2; nar++) begin
            for (int bi = 0; bi < 16; bi++) begin
                logic [3:0] be;
                be      = bi[3:0];
                a       = (nar << 6) | (bi << 2);
                wd      = 32'h13579BDF ^ (bi * 32'h11111111) ^ (nar != 0 ? 32'hF0F00F0F : 32'h0);
                split   = (nar != 0) && (|be[1:0]) && (|be[3:2]);
                hi_only = (be[1:0] == 2'b00) && (be != 4'b0);
                exp_c   = split ? 2 : 1;
                rtag    = split ? "R4" : "R6";

                // write
                do_op(1'b1, a, be, wd, bi % 3, rd, cyc, to, post_ok);
                chk(!to, "R8 write completes", {31'd0, to}, 32'd0);
                chk(cyc == exp_c, {rtag, " write cycle count"}, cyc, exp_c);
                chk(!hold_err, "R3 write hold in wait", {31'd0, hold_err}, 32'd0);
                chk(post_ok, "R8 write pulse", {31'd0, post_ok}, 32'd1);
                if (split) begin
                    chk(sec_addr == a + 32'd2, "R4 second address", sec_addr, a + 32'd2);
                    chk(sec_be == {be[3:2], 2'b00}, "R4 second enables", {28'd0, sec_be}, {28'd0, be[3:2], 2'b00});
                end
                shadow[bi + 16*nar] = (shadow[bi + 16*nar] & ~be_mask(be)) | (wd & be_mask(be));
                chk(dev_mem[bi + 16*nar] == shadow[bi + 16*nar],
                    hi_only ? "R7 high-half write lanes" : "R4 device contents",
                    dev_mem[bi + 16*nar], shadow[bi + 16*nar]);

                // read back
                do_op(1'b0, a, be, 32'h0, (bi + 1) % 3, rd, cyc, to, post_ok);
                exp = shadow[bi + 16*nar] & be_mask(be);
                chk(!to, "R8 read completes", {31'd0, to}, 32'd0);
                chk(cyc == exp_c, {rtag, " read cycle count"}, cyc, exp_c);
                chk(!hold_err, "R3 read hold in wait", {31'd0, hold_err}, 32'd0);
                chk(post_ok, "R8 read pulse", {31'd0, post_ok}, 32'd1);
                chk(rd == exp,
                    split ? "R5 split read data" : (nar != 0 && hi_only) ? "R7 high-half read" : "R2 read data",
                    rd, exp);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule